// File: doc/BRIEF.md
# Spare-Bit In-Band Code Detector

This block watches the time-slot-0 bytes of a received E1 stream that has already been aligned to frames and to 16-frame CRC-4 multiframes. From each odd-numbered frame it takes the A bit and the five national spare bits Sa4 to Sa8. Across one multiframe this gives an 8-sample word per field. A per-field select mask names which fields take part. The block declares an in-band code once the selected fields have carried the same words for a programmable number of back-to-back multiframes (8 by default).

Upstream framing logic supplies a strobe for each time-slot-0 byte, the frame number and a multiframe start marker. Control logic supplies a global enable and the select mask. The mask is sampled only at a multiframe start, so a change made part-way through a multiframe is applied from the next multiframe on. The block drives a detect flag and a copy of the pattern that was in place when detection began.

Top module: `spare_code_detect`

## Requirements
- R1: On a byte strobe with an odd frame number the block samples tsByte[5] as A, tsByte[4] as Sa4, tsByte[3] as Sa5, tsByte[2] as Sa6, tsByte[1] as Sa7 and tsByte[0] as Sa8. Strobes with an even frame number, and tsByte[7:6], have no effect on detection.
- R2: selMask bit 0 selects A, and bits 1 to 5 select Sa4 to Sa8 in that order. A field whose select bit is 0 does not take part in the comparison: its changes never break persistence, and its slice of codePattern reads 0.
- R3: The first complete multiframe after arming, or after a restart, counts as 1. Each following multiframe whose selected words equal those of the one before adds 1, and the count saturates at PERSIST.
- R4: codeDetect rises in the cycle after the frame-15 strobe that closes the PERSIST-th consecutive equal multiframe. It stays high while later multiframes keep repeating the same pattern.
- R5: codePattern holds field f (0 = A to 5 = Sa8) in bits [8f+7:8f], with the frame-1 sample in the top bit and the frame-15 sample in bit 0. It loads only when codeDetect rises, and it holds its value through later repeats and mismatches.
- R6: selMask is sampled only on the cycle where mfStart is high. A change made within a multiframe has no effect until the next multiframe start.
- R7: When a multiframe closes with a difference in any selected field, codeDetect clears in the next cycle and the count restarts at 1.
- R8: While enable is low, codeDetect is 0 from the next cycle on, and the count, the stored words and codePattern are cleared. After enable returns high, sampling resumes at the next mfStart.
- R9: With an all-zero mask in effect, no code is ever detected.
- R10: If the mask sampled at a multiframe start differs from the mask in use before it, persistence restarts and the new multiframe counts as 1.
- R11: A synchronous reset (rst high) clears codeDetect, the count and codePattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global detector enable |
| selMask | input | 6 | Field select: bit 0 A, bits 1..5 Sa4..Sa8 |
| tsValid | input | 1 | Strobe for one time-slot-0 byte |
| tsByte | input | 8 | Time-slot-0 byte, bit 7 received first |
| frameNum | input | 4 | Frame number 0..15 within the multiframe |
| mfStart | input | 1 | Multiframe start marker, high with the frame-0 strobe |
| codeDetect | output | 1 | In-band code detected |
| codePattern | output | 48 | Selected field words latched at detection |

## Verification
Every piece of internal state surfaces at one frame-15 close. A counter that is off by one moves the rise of codeDetect one multiframe early or late. A stale stored word or a wrongly applied mask either hides a real repeat or invents one. Each of these shows up within one multiframe (32 strobes and idle cycles in the bench), and a sampling error in the pattern word also shows up at once in codePattern. Mid-multiframe mask writes and enable drops are placed so that a boundary applied at the wrong time flips the flag at the very next close.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int FIELD_CNT = 6;
  localparam int ODD_CNT   = 8;
  localparam int PAT_W     = FIELD_CNT * ODD_CNT;
  localparam int FRAME_W   = 4;
  localparam int LAST_FRAME = 15;

  typedef struct packed {
    logic flush;
    logic shift;
    logic close;
    logic capture;
  } scdStrobe_t;
endpackage

// File: rtl/scd_ctrl.sv
module scd_ctrl
  import scd_pkg::*;
#(
  parameter int PERSIST = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [FIELD_CNT-1:0] selMask,
  input  logic                 tsValid,
  input  logic [FRAME_W-1:0]   frameNum,
  input  logic                 mfStart,
  input  logic                 patMatch,
  output scdStrobe_t           strobe,
  output logic [FIELD_CNT-1:0] activeMask,
  output logic                 codeDetect
);
  localparam int CNT_W = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PERSIST);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(PERSIST - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             armed;
  logic             havePrev;
  logic [CNT_W-1:0] count;
  logic             flushStb;
  logic             shiftStb;
  logic             closeStb;
  logic             captureStb;
  logic             repeatOk;
  logic             reachNow;
  logic             maskEmpty;

  always_comb begin
    flushStb   = rst || !enable;
    shiftStb   = armed && enable && tsValid && frameNum[0];
    closeStb   = shiftStb && (frameNum == FRAME_W'(LAST_FRAME));
    maskEmpty  = (activeMask == '0);
    repeatOk   = havePrev && patMatch && !maskEmpty;
    reachNow   = (count >= NEAR);
    captureStb = closeStb && repeatOk && reachNow && !codeDetect;
    strobe.flush   = flushStb;
    strobe.shift   = shiftStb;
    strobe.close   = closeStb;
    strobe.capture = captureStb;
  end

  always_ff @(posedge clk) begin
    if (flushStb) begin
      armed      <= 1'b0;
      havePrev   <= 1'b0;
      count      <= '0;
      codeDetect <= 1'b0;
      activeMask <= '0;
    end else begin
      if (mfStart) begin
        armed      <= 1'b1;
        activeMask <= selMask;
        if (selMask != activeMask) havePrev <= 1'b0;
      end
      if (closeStb) begin
        if (maskEmpty) begin
          count      <= '0;
          codeDetect <= 1'b0;
          havePrev   <= 1'b0;
        end else if (repeatOk) begin
          if (count != FULL) count <= count + ONE;
          if (reachNow) codeDetect <= 1'b1;
          havePrev <= 1'b1;
        end else begin
          count      <= ONE;
          codeDetect <= 1'b0;
          havePrev   <= 1'b1;
        end
      end
    end
  end

  // R3: the persistence count never passes its ceiling
  a_r3_count_capped: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  // R4: a detection always rests on a full count
  a_r4_detect_full: assert property (@(posedge clk) disable iff (rst)
    codeDetect |-> (count == FULL));
  // R4: detection starts only right after a multiframe close
  a_r4_rise_on_close: assert property (@(posedge clk) disable iff (rst)
    $rose(codeDetect) |-> $past(closeStb));
  // R6: the mask in use changes only at a boundary or when cleared
  a_r6_mask_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (!$stable(activeMask) && !$past(rst)) |-> $past(mfStart || !enable));
  // R8: the detector is idle while disabled
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !codeDetect);
  // R9: a close under an empty mask leaves no detection
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (closeStb && maskEmpty) |=> !codeDetect);
endmodule

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_pkg::*;
(
  input  logic                 clk,
  input  scdStrobe_t           strobe,
  input  logic [FIELD_CNT-1:0] activeMask,
  input  logic [7:0]           tsByte,
  output logic                 patMatch,
  output logic [PAT_W-1:0]     codePattern
);
  logic [PAT_W-1:0] shiftReg;
  logic [PAT_W-1:0] shiftNext;
  logic [PAT_W-1:0] maskWide;
  logic [PAT_W-1:0] curMasked;
  logic [PAT_W-1:0] prevPat;

  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
    assign shiftNext[f*ODD_CNT +: ODD_CNT] =
      {shiftReg[f*ODD_CNT +: ODD_CNT-1], tsByte[5-f]};
    assign maskWide[f*ODD_CNT +: ODD_CNT] = {ODD_CNT{activeMask[f]}};
  end

  assign curMasked = shiftNext & maskWide;
  assign patMatch  = (curMasked == prevPat);

  always_ff @(posedge clk) begin
    if (strobe.flush) begin
      shiftReg    <= '0;
      prevPat     <= '0;
      codePattern <= '0;
    end else if (strobe.shift) begin
      shiftReg <= shiftNext;
      if (strobe.close)   prevPat     <= curMasked;
      if (strobe.capture) codePattern <= curMasked;
    end
  end

  // R5: the latched pattern moves only on capture or clear
  a_r5_pattern_holds: assert property (@(posedge clk) disable iff (strobe.flush)
    !$stable(codePattern) |-> $past(strobe.capture || strobe.flush));
  // R1: stored words change only on a sampled odd-frame close
  a_r1_prev_on_close: assert property (@(posedge clk) disable iff (strobe.flush)
    !$stable(prevPat) |-> $past(strobe.close || strobe.flush));
endmodule

// File: rtl/spare_code_detect.sv
module spare_code_detect
  import scd_pkg::*;
#(
  parameter int PERSIST = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [FIELD_CNT-1:0] selMask,
  input  logic                 tsValid,
  input  logic [7:0]           tsByte,
  input  logic [FRAME_W-1:0]   frameNum,
  input  logic                 mfStart,
  output logic                 codeDetect,
  output logic [PAT_W-1:0]     codePattern
);
  scdStrobe_t           strobe;
  logic [FIELD_CNT-1:0] activeMask;
  logic                 patMatch;

  scd_ctrl #(.PERSIST(PERSIST)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .selMask    (selMask),
    .tsValid    (tsValid),
    .frameNum   (frameNum),
    .mfStart    (mfStart),
    .patMatch   (patMatch),
    .strobe     (strobe),
    .activeMask (activeMask),
    .codeDetect (codeDetect)
  );

  scd_datapath u_datapath (
    .clk         (clk),
    .strobe      (strobe),
    .activeMask  (activeMask),
    .tsByte      (tsByte),
    .patMatch    (patMatch),
    .codePattern (codePattern)
  );
endmodule

// File: tb/spare_code_detect_bench.sv
`timescale 1ns/1ps
module spare_code_detect_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic [5:0]  selMask = 6'h3F;
  logic        tsValid = 1'b0;
  logic [7:0]  tsByte = 8'h00;
  logic [3:0]  frameNum = 4'd0;
  logic        mfStart = 1'b0;
  logic        codeDetect;
  logic [47:0] codePattern;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spare_code_detect u_spare_code_detect (
    .clk(clk), .rst(rst), .enable(enable), .selMask(selMask),
    .tsValid(tsValid), .tsByte(tsByte), .frameNum(frameNum),
    .mfStart(mfStart), .codeDetect(codeDetect), .codePattern(codePattern)
  );

  localparam logic [47:0] P1 = 48'hA5C3_0F96_3C5A;
  localparam logic [47:0] P2 = P1 ^ 48'h0000_0000_0001;
  localparam logic [47:0] SA4_BITS = 48'h0000_0000_FF00;

  typedef struct packed {
    logic [5:0]  mask;
    logic [47:0] pat;
    logic        det;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{6'h3F, P1, 1'b0}, '{6'h3F, P1, 1'b0}, '{6'h3F, P1, 1'b0},
    '{6'h3F, P1, 1'b0}, '{6'h3F, P1, 1'b0}, '{6'h3F, P1, 1'b0},
    '{6'h3F, P1, 1'b0}, '{6'h3F, P1, 1'b1}, '{6'h3F, P1, 1'b1},
    '{6'h3F, P2, 1'b0}, '{6'h3F, P2, 1'b0}, '{6'h3F, P1, 1'b0}
  };

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendTs(input int fr, input logic [7:0] b);
    @(negedge clk);
    tsValid  = 1'b1;
    frameNum = 4'(fr);
    tsByte   = b;
    mfStart  = (fr == 0);
    @(negedge clk);
    tsValid = 1'b0;
    mfStart = 1'b0;
  endtask

  // one multiframe; newMask is applied just before frame midFrame (-1: never)
  task automatic sendMf(input logic [47:0] pat, input logic [7:0] seed,
                        input logic [5:0] newMask, input int midFrame);
    for (int fr = 0; fr < 16; fr++) begin
      logic [7:0] b;
      if (fr == midFrame) selMask = newMask;
      if (fr % 2 == 1) begin
        b = {seed[0], 1'b1, 6'b0};
        for (int f = 0; f < 6; f++) b[5-f] = pat[f*8 + 7 - fr/2];
      end else begin
        b = seed ^ 8'(fr * 17);
      end
      sendTs(fr, b);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R11 reset detect", 64'(codeDetect), 64'd0);
    checkEq("R11 reset pattern", 64'(codePattern), 64'd0);

    // table walk: persistence, hold, mismatch restart (R3 R4 R5 R7)
    for (int i = 0; i < 12; i++) begin
      selMask = VECS[i].mask;
      sendMf(VECS[i].pat, 8'(i * 13), VECS[i].mask, -1);
      checkEq($sformatf("R4/R7 table row %0d detect", i), 64'(codeDetect), 64'(VECS[i].det));
      if (i == 7 || i == 11)
        checkEq($sformatf("R5 table row %0d pattern", i), 64'(codePattern), 64'(P1));
    end

    // R1: even-frame bytes and the top two bits vary, odd samples fixed
    doReset();
    for (int i = 0; i < 8; i++) begin
      sendMf(P1, 8'(i * 37 + 5), 6'h3F, -1);
      if (i == 6) checkEq("R3 seventh multiframe not yet", 64'(codeDetect), 64'd0);
    end
    checkEq("R1 even frames ignored detect", 64'(codeDetect), 64'd1);
    checkEq("R1 pattern from odd frames", 64'(codePattern), 64'(P1));

    // R2: only Sa4 selected, other fields churn
    doReset();
    selMask = 6'b000010;
    for (int i = 0; i < 8; i++) begin
      logic [47:0] pat;
      pat = (P1 & SA4_BITS) | ({6{8'(i * 29 + 3)}} & ~SA4_BITS);
      sendMf(pat, 8'h11, 6'b000010, -1);
    end
    checkEq("R2 unselected changes ignored", 64'(codeDetect), 64'd1);
    checkEq("R2 unselected slices zero", 64'(codePattern), 64'(P1 & SA4_BITS));

    // R6: mask write in mid multiframe applies only from the next one
    sendMf(P2 ^ 48'h0000_0000_0010, 8'h22, 6'h3F, 5);
    checkEq("R6 mid-multiframe mask write deferred", 64'(codeDetect), 64'd1);
    // R10: new mask at boundary restarts persistence
    sendMf(P1, 8'h22, 6'h3F, -1);
    checkEq("R10 mask change restarts", 64'(codeDetect), 64'd0);
    for (int i = 0; i < 7; i++) begin
      sendMf(P1, 8'h33, 6'h3F, -1);
      if (i == 5) checkEq("R10 count restarted at one", 64'(codeDetect), 64'd0);
    end
    checkEq("R10 detect after eight under new mask", 64'(codeDetect), 64'd1);

    // R8: enable low clears and idles
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    checkEq("R8 detect cleared when disabled", 64'(codeDetect), 64'd0);
    checkEq("R8 pattern cleared when disabled", 64'(codePattern), 64'd0);
    enable = 1'b1;
    sendMf(P1, 8'h44, 6'h3F, -1);
    checkEq("R8 restart counts from one", 64'(codeDetect), 64'd0);

    // R9: empty mask never detects
    doReset();
    selMask = 6'h00;
    for (int i = 0; i < 10; i++) sendMf(P1, 8'h55, 6'h00, -1);
    checkEq("R9 empty mask no detect", 64'(codeDetect), 64'd0);

    // R11: reset after detection
    selMask = 6'h3F;
    doReset();
    for (int i = 0; i < 8; i++) sendMf(P2, 8'h66, 6'h3F, -1);
    checkEq("R11 pre-reset detect", 64'(codeDetect), 64'd1);
    doReset();
    checkEq("R11 detect cleared by reset", 64'(codeDetect), 64'd0);
    checkEq("R11 pattern cleared by reset", 64'(codePattern), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule